// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 synchronous interrupt request lines and drives two request outputs to a processor: a fast line and a normal line. Source 0 is the fast-interrupt input. Source 1 carries the combined system-peripheral request, which the block handles as an ordinary source. Each source has an enable bit, a trigger type, a 3-bit priority and a 32-bit vector. Any source can be forced onto the fast line. A global mask silences both outputs while pending events stay visible.

Software reads a vector register to get the vector of the winning normal source. That read records the winner's priority as in service and clears the winner's edge latch. A later end-of-service write releases the most recent level. A source of higher priority than every level in service can interrupt again, so handlers nest. If nothing qualifies when the vector register is read, the read returns a programmable spurious vector. A protect bit turns off the read side effects so that a debugger can look without changing state.

The register port is a simple read/write strobe bus. Read data is valid one cycle after the read strobe.

Top module: `vic_top`

## Requirements
- R1: After reset both interrupt outputs are low, all enables and force bits are clear, no level is in service, the spurious vector reads 0 and every mode word reads 0.
- R2: A source asserts an output only while its enable bit is set. Writing ones to the enable-set word (0x000) sets bits and writing ones to the enable-clear word (0x004) clears bits. Reading 0x000 returns the enables.
- R3: Mode word bits [5:4] select the trigger: 00 high level, 01 rising edge, 10 low level, 11 falling edge. An edge is latched as pending until it is cleared. The pending word (read 0x008) shows bit i set while source i is pending.
- R4: On a source that is not external, the polarity bit (mode bit 5) is stored as 0. That source then acts as high-level or rising-edge.
- R5: Source 0, and any source whose force bit is set (set 0x00C, clear 0x010), drives only the fast output and never the normal output.
- R6: The normal output is high one cycle after an enabled, pending, non-fast source exists whose priority (mode bits [2:0]) is above every level in service. A vector read (0x014) returns the vector (table at 0x800 + 4*i) of the highest-priority such source, and the lowest source number wins a tie.
- R7: Outside protect mode, a vector read marks the winner's priority as in service and clears its edge latch. After that, only a strictly higher priority can raise the normal output again. The in-service levels read back as a bitmap at 0x024, with bit p for level p.
- R8: A write to the end-of-service word (0x018) releases the highest level in service.
- R9: A vector read with no qualifying source returns the spurious vector (0x020) and marks nothing in service.
- R10: With protect set (control word 0x01C bit 0), a vector read returns the same vector but changes neither the in-service levels nor the pending latches.
- R11: With the global mask set (control bit 1), both outputs stay low, and the pending word still shows new events.
- R12: Writing ones to the pending word (0x008) clears the matching edge latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Interrupt request lines, already synchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The checks assume that the request lines are already synchronous to the clock, and that the read and write strobes are never high in the same cycle. This matters because a vector read and an end-of-service write in one cycle would push and pop together. The stimulus changes request lines and strobes only at falling edges and issues each register access as a one-cycle strobe, with no overlap. It also lets the outputs settle for a few cycles before it samples them. End-of-service writes are issued only after a level has been put in service, apart from the cleanup writes.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  // address regions, decoded from the two top address bits
  localparam logic [1:0] REG_CTL  = 2'd0;
  localparam logic [1:0] REG_MODE = 2'd1;
  localparam logic [1:0] REG_VECT = 2'd2;

  // control region offsets
  localparam logic [9:0] OFF_EN_SET = 10'h000;
  localparam logic [9:0] OFF_EN_CLR = 10'h004;
  localparam logic [9:0] OFF_PEND   = 10'h008;
  localparam logic [9:0] OFF_FSET   = 10'h00C;
  localparam logic [9:0] OFF_FCLR   = 10'h010;
  localparam logic [9:0] OFF_VEC    = 10'h014;
  localparam logic [9:0] OFF_EOI    = 10'h018;
  localparam logic [9:0] OFF_CTRL   = 10'h01C;
  localparam logic [9:0] OFF_SPUR   = 10'h020;
  localparam logic [9:0] OFF_LVL    = 10'h024;

  // trigger encodings: bit0 = edge, bit1 = inverted polarity
  typedef enum logic [1:0] {
    TRG_HIGH = 2'b00,
    TRG_RISE = 2'b01,
    TRG_LOW  = 2'b10,
    TRG_FALL = 2'b11
  } trig_e;

  localparam int TRIG_LSB = 4;
endpackage

// File: rtl/vic_src.sv
`timescale 1ns/1ps
module vic_src (
  input  logic       clk,
  input  logic       rst,
  input  logic       src_i,
  input  logic [1:0] trig_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic src_q;
  logic latch_q;
  logic edge_hit;

  always_comb begin
    edge_hit = trig_i[0] & (trig_i[1] ? (~src_i & src_q) : (src_i & ~src_q));
    pend_o   = trig_i[0] ? latch_q : (src_i ^ trig_i[1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      src_q <= src_i;
      if (edge_hit)   latch_q <= 1'b1;
      else if (clr_i) latch_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vic_arb.sv
`timescale 1ns/1ps
module vic_arb #(
  parameter int N  = 32,
  parameter int LW = 3,
  parameter int IW = 5
) (
  input  logic [N-1:0]    cand_i,
  input  logic [N*LW-1:0] prio_i,
  output logic            found_o,
  output logic [IW-1:0]   idx_o,
  output logic [LW-1:0]   prio_o
);
  // scan from the top index down; ">=" lets lower indices win ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i] && (!found_o || prio_i[i*LW +: LW] >= prio_o)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        prio_o  = prio_i[i*LW +: LW];
      end
    end
  end
endmodule

// File: rtl/vic_lvl.sv
`timescale 1ns/1ps
module vic_lvl #(
  parameter int NLVL = 8,
  parameter int LW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_i,
  input  logic [LW-1:0]   push_lvl_i,
  input  logic            pop_i,
  output logic            any_o,
  output logic [LW-1:0]   cur_o,
  output logic [NLVL-1:0] map_o
);
  logic [NLVL-1:0] map_q;
  logic [NLVL-1:0] top_oh;
  logic [NLVL-1:0] set_oh;

  always_comb begin
    cur_o  = '0;
    top_oh = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (map_q[l]) cur_o = LW'(l);
    end
    if (|map_q) top_oh[cur_o] = 1'b1;
    set_oh = push_i ? (NLVL'(1) << push_lvl_i) : '0;
    any_o  = |map_q;
    map_o  = map_q;
  end

  always_ff @(posedge clk) begin
    if (rst) map_q <= '0;
    else     map_q <= (map_q & ~(pop_i ? top_oh : '0)) | set_oh;
  end
endmodule

// File: rtl/vic_top.sv
`timescale 1ns/1ps
module vic_top
  import vic_pkg::*;
#(
  parameter int              NSRC     = 32,
  parameter int              NLVL     = 8,
  parameter int              AW       = 12,
  parameter int              DW       = 32,
  parameter logic [NSRC-1:0] EXT_MASK = 32'hF000_0001
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int LW = $clog2(NLVL);
  localparam int IW = $clog2(NSRC);

  // configuration state
  logic [NSRC-1:0] en_q, force_q;
  logic            protect_q, gmask_q;
  logic [DW-1:0]   spur_q;
  logic [LW-1:0]   prio_q [NSRC];
  logic [1:0]      trig_q [NSRC];
  logic [DW-1:0]   vtab   [NSRC];
  logic [DW-1:0]   vq;

  // decode
  logic [1:0]    region;
  logic [AW-3:0] off;
  logic [IW-1:0] sidx;
  logic          ctl_wr, ctl_rd, vrd, eoi_wr, iclr_wr, take;

  always_comb begin
    region  = addr_i[AW-1:AW-2];
    off     = addr_i[AW-3:0];
    sidx    = addr_i[IW+1:2];
    ctl_wr  = wr_en_i && (region == REG_CTL);
    ctl_rd  = rd_en_i && (region == REG_CTL);
    vrd     = ctl_rd && (off == OFF_VEC);
    eoi_wr  = ctl_wr && (off == OFF_EOI);
    iclr_wr = ctl_wr && (off == OFF_PEND);
  end

  // per-source trigger logic
  logic [NSRC-1:0]    pend, clr_vec, active, fiq_sel, irq_cand;
  logic [NSRC*LW-1:0] prio_flat;
  logic               found, fast_act, preempt;
  logic [IW-1:0]      widx;
  logic [LW-1:0]      wprio;
  logic               lv_any;
  logic [LW-1:0]      lv_cur;
  logic [NLVL-1:0]    lv_map;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    vic_src u_src (
      .clk    (clk),
      .rst    (rst),
      .src_i  (src_i[g]),
      .trig_i (trig_q[g]),
      .clr_i  (clr_vec[g]),
      .pend_o (pend[g])
    );
    assign prio_flat[g*LW +: LW] = prio_q[g];
  end

  always_comb begin
    active   = pend & en_q;
    fiq_sel  = force_q | NSRC'(1);
    irq_cand = active & ~fiq_sel;
    fast_act = |(active & fiq_sel);
  end

  vic_arb #(.N(NSRC), .LW(LW), .IW(IW)) u_arb (
    .cand_i  (irq_cand),
    .prio_i  (prio_flat),
    .found_o (found),
    .idx_o   (widx),
    .prio_o  (wprio)
  );

  always_comb begin
    preempt = found && (!lv_any || wprio > lv_cur);
    take    = vrd && preempt && !protect_q;
    clr_vec = (iclr_wr ? wdata_i[NSRC-1:0] : '0) |
              (take ? (NSRC'(1) << widx) : '0);
  end

  vic_lvl #(.NLVL(NLVL), .LW(LW)) u_lvl (
    .clk        (clk),
    .rst        (rst),
    .push_i     (take),
    .push_lvl_i (wprio),
    .pop_i      (eoi_wr),
    .any_o      (lv_any),
    .cur_o      (lv_cur),
    .map_o      (lv_map)
  );

  // control writes
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      force_q   <= '0;
      protect_q <= 1'b0;
      gmask_q   <= 1'b0;
      spur_q    <= '0;
    end else if (ctl_wr) begin
      case (off)
        OFF_EN_SET: en_q    <= en_q | wdata_i[NSRC-1:0];
        OFF_EN_CLR: en_q    <= en_q & ~wdata_i[NSRC-1:0];
        OFF_FSET:   force_q <= force_q | wdata_i[NSRC-1:0];
        OFF_FCLR:   force_q <= force_q & ~wdata_i[NSRC-1:0];
        OFF_CTRL: begin
          protect_q <= wdata_i[0];
          gmask_q   <= wdata_i[1];
        end
        OFF_SPUR:   spur_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  // mode words; polarity only kept on external sources
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= '0;
        trig_q[i] <= TRG_HIGH;
      end
    end else if (wr_en_i && region == REG_MODE) begin
      prio_q[sidx] <= wdata_i[LW-1:0];
      trig_q[sidx] <= {wdata_i[TRIG_LSB+1] & EXT_MASK[sidx], wdata_i[TRIG_LSB]};
    end
  end

  // vector table: one write port, one synchronous read port
  logic [IW-1:0] vraddr;
  assign vraddr = vrd ? widx : sidx;

  always_ff @(posedge clk) begin
    if (wr_en_i && region == REG_VECT) vtab[sidx] <= wdata_i;
    vq <= vtab[vraddr];
  end

  // read path
  logic [DW-1:0] mode_word;
  logic [DW-1:0] reg_q;
  logic          use_vec_q;

  always_comb begin
    mode_word                          = '0;
    mode_word[LW-1:0]                  = prio_q[sidx];
    mode_word[TRIG_LSB+1:TRIG_LSB]     = trig_q[sidx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      use_vec_q <= 1'b0;
    end else if (rd_en_i) begin
      use_vec_q <= 1'b0;
      reg_q     <= '0;
      case (region)
        REG_CTL: begin
          case (off)
            OFF_EN_SET: reg_q <= DW'(en_q);
            OFF_PEND:   reg_q <= DW'(pend);
            OFF_FSET:   reg_q <= DW'(force_q);
            OFF_VEC: begin
              if (preempt) use_vec_q <= 1'b1;
              else         reg_q     <= spur_q;
            end
            OFF_CTRL:   reg_q <= DW'({gmask_q, protect_q});
            OFF_SPUR:   reg_q <= spur_q;
            OFF_LVL:    reg_q <= DW'(lv_map);
            default: ;
          endcase
        end
        REG_MODE: reg_q     <= mode_word;
        REG_VECT: use_vec_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign rdata_o = use_vec_q ? vq : reg_q;

  // registered request outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= preempt & ~gmask_q;
      fiq_o <= fast_act & ~gmask_q;
    end
  end
endmodule

// File: rtl/vic_chk.sv
`timescale 1ns/1ps
module vic_chk #(
  parameter int NLVL = 8,
  parameter int LW   = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_o,
  input logic            fiq_o,
  input logic            gmask,
  input logic            protect,
  input logic            vrd,
  input logic            eoi,
  input logic            push,
  input logic [LW-1:0]   push_lvl,
  input logic            lv_any,
  input logic [LW-1:0]   lv_cur,
  input logic [NLVL-1:0] lv_map,
  input logic            fast_act,
  input logic            found
);
  // R11
  gmask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    gmask |=> (!irq_o && !fiq_o));

  // R5
  fiq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past(fast_act));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(found));

  // R7
  push_above_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (!lv_any || push_lvl > lv_cur));

  // R10
  protect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vrd && protect && !eoi) |=> $stable(lv_map));

  // R8
  eoi_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi && lv_any && !push) |=> ($countones(lv_map) == $countones($past(lv_map)) - 1));
endmodule

bind vic_top vic_chk #(.NLVL(NLVL), .LW(LW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .gmask    (gmask_q),
  .protect  (protect_q),
  .vrd      (vrd),
  .eoi      (eoi_wr),
  .push     (take),
  .push_lvl (wprio),
  .lv_any   (lv_any),
  .lv_cur   (lv_cur),
  .lv_map   (lv_map),
  .fast_act (fast_act),
  .found    (found)
);

// File: tb/tb_vic_top.sv
`timescale 1ns/1ps
module tb_vic_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          total = 0;
  int          bad = 0;

  always #2 clk = ~clk;

  vic_top dut (
    .clk     (clk),
    .rst     (rst),
    .src_i   (src),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq),
    .fiq_o   (fiq)
  );

  localparam logic [11:0] A_EN_SET = 12'h000, A_EN_CLR = 12'h004, A_PEND = 12'h008,
                          A_FSET = 12'h00C, A_FCLR = 12'h010, A_VEC = 12'h014,
                          A_EOI = 12'h018, A_CTRL = 12'h01C, A_SPUR = 12'h020,
                          A_LVL = 12'h024;

  function automatic logic [11:0] a_mode(input int i); return 12'h400 + 12'(4*i); endfunction
  function automatic logic [11:0] a_vec(input int i);  return 12'h800 + 12'(4*i); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 fiq", 32'(fiq), 0);
    rd(A_EN_SET, d); chk("R1 enables", d, 0);
    rd(A_FSET, d);   chk("R1 force", d, 0);
    rd(A_LVL, d);    chk("R1 levels", d, 0);
    rd(A_SPUR, d);   chk("R1 spurious", d, 0);
    rd(a_mode(7), d); chk("R1 mode", d, 0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(a_vec(5), 32'h0000_5005);
    wr(a_mode(5), 32'h3);
    src[5] = 1'b1; idle(3);
    chk("R2 disabled source quiet", 32'(irq), 0);
    wr(A_EN_SET, 32'h20);
    rd(A_EN_SET, d); chk("R2 enable readback", d, 32'h20);
    idle(2);
    chk("R6 irq raised", 32'(irq), 1);
    chk("R5 fiq stays low", 32'(fiq), 0);
    rd(A_VEC, d); chk("R6 vector", d, 32'h5005);
    idle(2);
    chk("R7 irq dropped in service", 32'(irq), 0);
    rd(A_LVL, d); chk("R7 level map", d, 32'h08);
    wr(A_EOI, 0);
    rd(A_LVL, d); chk("R8 level released", d, 0);
    idle(2);
    chk("R8 level source reasserts", 32'(irq), 1);
    src[5] = 1'b0; idle(3);
    chk("R3 high level gone", 32'(irq), 0);
    wr(A_EN_CLR, 32'h20);
    rd(A_EN_SET, d); chk("R2 enable cleared", d, 0);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    wr(a_vec(3), 32'h303); wr(a_vec(9), 32'h909); wr(a_vec(10), 32'hA0A);
    wr(a_mode(3), 32'h4); wr(a_mode(9), 32'h4); wr(a_mode(10), 32'h6);
    wr(A_EN_SET, 32'h608);
    src[3] = 1'b1; src[9] = 1'b1; idle(3);
    rd(A_VEC, d); chk("R6 tie lowest index", d, 32'h303);
    idle(2);
    chk("R7 equal priority blocked", 32'(irq), 0);
    src[10] = 1'b1; idle(3);
    chk("R7 higher priority nests", 32'(irq), 1);
    rd(A_VEC, d); chk("R6 highest priority vector", d, 32'hA0A);
    rd(A_LVL, d); chk("R7 two levels", d, 32'h50);
    wr(A_EOI, 0);
    rd(A_LVL, d); chk("R8 pops top level", d, 32'h10);
    idle(2);
    chk("R8 higher source asks again", 32'(irq), 1);
    src[3] = 1'b0; src[9] = 1'b0; src[10] = 1'b0;
    wr(A_EOI, 0);
    rd(A_LVL, d); chk("R8 all released", d, 0);
    wr(A_EN_CLR, 32'h608);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr(a_vec(12), 32'hC0C);
    wr(a_mode(12), 32'h11);
    wr(A_EN_SET, 32'h1000);
    @(negedge clk); src[12] = 1'b1;
    @(negedge clk); src[12] = 1'b0;
    idle(3);
    rd(A_PEND, d); chk("R3 rising edge latched", d & 32'h1000, 32'h1000);
    chk("R3 edge raises irq", 32'(irq), 1);
    rd(A_VEC, d); chk("R6 edge vector", d, 32'hC0C);
    rd(A_PEND, d); chk("R7 edge latch cleared", d & 32'h1000, 0);
    wr(A_EOI, 0); idle(2);
    chk("R7 no retrigger", 32'(irq), 0);
    // falling edge on external source 30
    wr(a_mode(30), 32'h32);
    src[30] = 1'b1; idle(3);
    rd(A_PEND, d); chk("R3 rise ignored by falling", d & 32'h4000_0000, 0);
    src[30] = 1'b0; idle(3);
    rd(A_PEND, d); chk("R3 falling edge latched", d & 32'h4000_0000, 32'h4000_0000);
    wr(A_PEND, 32'h4000_0000);
    rd(A_PEND, d); chk("R12 latch cleared by write", d & 32'h4000_0000, 0);
    // low level on external source 29
    wr(a_mode(29), 32'h22);
    rd(A_PEND, d); chk("R3 low level pending", d & 32'h2000_0000, 32'h2000_0000);
    src[29] = 1'b1; idle(2);
    rd(A_PEND, d); chk("R3 low level released", d & 32'h2000_0000, 0);
  endtask

  task automatic t_internal;
    logic [31:0] d;
    wr(a_mode(13), 32'h31);
    rd(a_mode(13), d); chk("R4 polarity dropped", d, 32'h11);
    @(negedge clk); src[13] = 1'b1; idle(3);
    rd(A_PEND, d); chk("R4 acts as rising", d & 32'h2000, 32'h2000);
    src[13] = 1'b0;
    wr(A_PEND, 32'h2000);
  endtask

  task automatic t_fiq;
    wr(A_EN_SET, 32'h1);
    src[0] = 1'b1; idle(3);
    chk("R5 source0 fiq", 32'(fiq), 1);
    chk("R5 source0 not irq", 32'(irq), 0);
    src[0] = 1'b0; idle(3);
    chk("R5 fiq drops", 32'(fiq), 0);
    wr(A_EN_SET, 32'h20);
    wr(A_FSET, 32'h20);
    src[5] = 1'b1; idle(3);
    chk("R5 forced to fiq", 32'(fiq), 1);
    chk("R5 forced not irq", 32'(irq), 0);
    wr(A_FCLR, 32'h20); idle(3);
    chk("R5 unforced irq", 32'(irq), 1);
    chk("R5 unforced fiq low", 32'(fiq), 0);
    src[5] = 1'b0; idle(2);
  endtask

  task automatic t_spur;
    logic [31:0] d;
    wr(A_SPUR, 32'hDEAD_BEEF);
    rd(A_VEC, d); chk("R9 spurious vector", d, 32'hDEAD_BEEF);
    rd(A_LVL, d); chk("R9 nothing in service", d, 0);
  endtask

  task automatic t_protect;
    logic [31:0] d;
    wr(A_CTRL, 32'h1);
    @(negedge clk); src[12] = 1'b1;
    @(negedge clk); src[12] = 1'b0;
    idle(3);
    rd(A_VEC, d); chk("R10 vector returned", d, 32'hC0C);
    rd(A_LVL, d); chk("R10 no level push", d, 0);
    rd(A_PEND, d); chk("R10 latch kept", d & 32'h1000, 32'h1000);
    chk("R10 irq still high", 32'(irq), 1);
    wr(A_CTRL, 32'h0);
    rd(A_VEC, d); chk("R7 read after protect", d, 32'hC0C);
    wr(A_EOI, 0);
  endtask

  task automatic t_gmask;
    logic [31:0] d;
    wr(A_CTRL, 32'h2);
    src[5] = 1'b1; src[0] = 1'b1; idle(3);
    chk("R11 irq masked", 32'(irq), 0);
    chk("R11 fiq masked", 32'(fiq), 0);
    rd(A_PEND, d); chk("R11 event visible", d & 32'h21, 32'h21);
    wr(A_CTRL, 32'h0); idle(3);
    chk("R11 irq after unmask", 32'(irq), 1);
    chk("R11 fiq after unmask", 32'(fiq), 1);
    src = '0;
    wr(A_EN_CLR, 32'hFFFF_FFFF);
    idle(3);
    chk("R2 all disabled", 32'(irq | fiq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_level();
    t_prio();
    t_edge();
    t_internal();
    t_fiq();
    t_spur();
    t_protect();
    t_gmask();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule